// File: doc/BRIEF.md
# Constant-Coefficient Fixed-Point Gain

This block multiplies a signed two's-complement sample by a coefficient that is fixed when the design is elaborated. It builds no general multiplier. At elaboration the coefficient is recoded into radix-4 signed digits, each drawn from {-2, -1, 0, +1, +2}. Every non-zero digit becomes one shifted copy of the input, either added or subtracted. Digits equal to zero produce no hardware. The copies are summed to form the exact product. The block is purely combinational, so the result follows the input with no clock or register on the path.

The exact product is `DIN_W + K_W` bits wide. An output window is cut from it. The parameter `DROP_MSB` discards a number of top bits that only repeat the sign; a well-scaled coefficient needs no more than one. The next `RES_W` bits form the result. Every bit below that field is truncated, so the result is the floored quotient of the product by a power of two. A design instantiates one such gain for each constant multiplication in a fixed-point datapath, with the window chosen by its word-length plan.

Top module: `ccg_gain`

## Requirements
- R1: The result equals the `RES_W` bits of the exact `(DIN_W+K_W)`-bit two's-complement product that lie directly below its `DROP_MSB` most significant bits. The result LSB is product bit `DIN_W+K_W-DROP_MSB-RES_W`.
- R2: With `DROP_MSB=0` and `RES_W=DIN_W+K_W`, the result read as signed equals din*COEF for every input, for positive coefficients including 1 and powers of two.
- R3: A zero coefficient gives an all-zero result for every input, and a zero input gives an all-zero result for every coefficient.
- R4: The most negative coefficient (only the top bit set) is multiplied correctly, including with the most negative input, where the full product is +2^(DIN_W+K_W-2).
- R5: A negative coefficient gives the negated product. In full-width form, the result sign bit for non-zero operands is the XOR of the two operand sign bits.
- R6: The dropped LSBs are truncated, not rounded. The result equals floor(product / 2^L) modulo 2^RES_W, where L is the number of truncated bits.
- R7: With `DROP_MSB=1` and a coefficient other than the most negative value, the kept field holds floor(product / 2^L) as a signed `RES_W`-bit value with no wraparound.
- R8: Odd and even coefficient widths are both recoded correctly. The top digit takes the coefficient's sign bit as its sign extension.
- R9: The path is combinational. The result reflects a new input without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| din | input | DIN_W | Signed two's-complement input sample |
| res | output | RES_W | Window cut from the exact signed product |

## Verification
Both window cuts, removing redundant sign MSBs and truncating LSBs, act on the same product in the same evaluation. An error in one can hide behind the other. To provoke this, an instance with one dropped MSB and four truncated LSBs is swept over every input value. A second instance, built on the most negative coefficient, truncates six LSBs and has its product reach the positive extreme. Each result is judged against a floored division of the integer product computed in the bench: as a signed value on the first instance, and bit for bit on the second.

// File: rtl/ccg_pkg.sv
package ccg_pkg;

    typedef enum logic [1:0] {
        MAG_NONE = 2'd0,
        MAG_ONE  = 2'd1,
        MAG_TWO  = 2'd2
    } mag_e;

    typedef struct packed {
        logic neg;
        mag_e mag;
    } bdig_t;

    function automatic int unsigned num_digits(input int unsigned kw);
        return (kw + 1) / 2;
    endfunction

    // coefficient bit j, sign-extended above the top bit
    function automatic int kbit(input logic signed [63:0] k,
                                input int unsigned kw,
                                input int unsigned j);
        if (j >= kw)
            return int'(k[kw-1]);
        return int'(k[j]);
    endfunction

    // radix-4 signed digit idx of the coefficient
    function automatic bdig_t booth_digit(input logic signed [63:0] k,
                                          input int unsigned kw,
                                          input int unsigned idx);
        int    v;
        bdig_t d;
        v = -2 * kbit(k, kw, 2*idx + 1) + kbit(k, kw, 2*idx);
        if (idx != 0)
            v = v + kbit(k, kw, 2*idx - 1);
        d.neg = (v < 0);
        case ((v < 0) ? -v : v)
            1:       d.mag = MAG_ONE;
            2:       d.mag = MAG_TWO;
            default: d.mag = MAG_NONE;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/ccg_booth_term.sv
module ccg_booth_term
    import ccg_pkg::*;
#(
    parameter int unsigned DIN_W  = 8,
    parameter int unsigned PROD_W = 16,
    parameter int unsigned SHIFT  = 0,
    parameter bdig_t       DIG    = '{neg: 1'b0, mag: MAG_ONE}
) (
    input  logic [DIN_W-1:0]  din,
    output logic [PROD_W-1:0] term
);
    localparam int unsigned EXT_W = PROD_W - DIN_W;

    logic [PROD_W-1:0] din_ext;
    logic [PROD_W-1:0] mag_val;
    logic [PROD_W-1:0] placed;

    assign din_ext = {{EXT_W{din[DIN_W-1]}}, din};

    generate
        if (DIG.mag == MAG_TWO) begin : g_two
            assign mag_val = din_ext << 1;
        end else begin : g_one
            assign mag_val = din_ext;
        end
    endgenerate

    assign placed = mag_val << SHIFT;

    generate
        if (DIG.neg) begin : g_sub
            assign term = (~placed) + 1'b1;
        end else begin : g_add
            assign term = placed;
        end
    endgenerate

endmodule

// File: rtl/ccg_term_sum.sv
module ccg_term_sum #(
    parameter int unsigned N_TERMS = 4,
    parameter int unsigned PROD_W  = 16
) (
    input  logic [N_TERMS-1:0][PROD_W-1:0] terms,
    output logic [PROD_W-1:0]              sum
);
    logic [N_TERMS:0][PROD_W-1:0] acc;

    assign acc[0] = '0;

    generate
        for (genvar i = 0; i < N_TERMS; i++) begin : g_acc
            assign acc[i+1] = acc[i] + terms[i];
        end
    endgenerate

    assign sum = acc[N_TERMS];

endmodule

// File: rtl/ccg_out_window.sv
module ccg_out_window #(
    parameter int unsigned PROD_W   = 16,
    parameter int unsigned DROP_MSB = 1,
    parameter int unsigned RES_W    = 12
) (
    input  logic [PROD_W-1:0] prod,
    output logic [RES_W-1:0]  res
);
    localparam int unsigned LSB_CUT = PROD_W - DROP_MSB - RES_W;

    generate
        if (DROP_MSB + RES_W > PROD_W) begin : g_bad
            $error("output window exceeds product width");
        end
    endgenerate

    assign res = RES_W'(prod >> LSB_CUT);

endmodule

// File: rtl/ccg_gain.sv
module ccg_gain
    import ccg_pkg::*;
#(
    parameter int unsigned             DIN_W    = 8,
    parameter int unsigned             K_W      = 8,
    parameter logic signed [K_W-1:0]   COEF     = 8'sb0101_1101,
    parameter int unsigned             DROP_MSB = 1,
    parameter int unsigned             RES_W    = 12
) (
    input  logic [DIN_W-1:0] din,
    output logic [RES_W-1:0] res
);
    localparam int unsigned       PROD_W = DIN_W + K_W;
    localparam int unsigned       NDIG   = num_digits(K_W);
    localparam logic signed [63:0] COEF_X = 64'(COEF);

    logic [NDIG-1:0][PROD_W-1:0] terms;
    logic [PROD_W-1:0]           prod;

    generate
        for (genvar i = 0; i < NDIG; i++) begin : g_dig
            localparam bdig_t D = booth_digit(COEF_X, K_W, i);
            if (D.mag == MAG_NONE) begin : g_zero
                assign terms[i] = '0;
            end else begin : g_term
                ccg_booth_term #(
                    .DIN_W (DIN_W),
                    .PROD_W(PROD_W),
                    .SHIFT (2*i),
                    .DIG   (D)
                ) u_term (
                    .din (din),
                    .term(terms[i])
                );
            end
        end
    endgenerate

    ccg_term_sum #(
        .N_TERMS(NDIG),
        .PROD_W (PROD_W)
    ) u_sum (
        .terms(terms),
        .sum  (prod)
    );

    ccg_out_window #(
        .PROD_W  (PROD_W),
        .DROP_MSB(DROP_MSB),
        .RES_W   (RES_W)
    ) u_win (
        .prod(prod),
        .res (res)
    );

endmodule

// File: rtl/ccg_gain_chk.sv
module ccg_gain_chk #(
    parameter int unsigned           DIN_W    = 8,
    parameter int unsigned           K_W      = 8,
    parameter logic signed [K_W-1:0] COEF     = 8'sb0101_1101,
    parameter int unsigned           DROP_MSB = 1,
    parameter int unsigned           RES_W    = 12
) (
    input logic [DIN_W-1:0] din,
    input logic [RES_W-1:0] res
);
    localparam int unsigned        PROD_W  = DIN_W + K_W;
    localparam int unsigned        LSB_CUT = PROD_W - DROP_MSB - RES_W;
    localparam logic signed [63:0] COEF_X  = 64'(COEF);
    localparam bit                 FULL    = (DROP_MSB == 0) && (LSB_CUT == 0);

    logic signed [63:0] din_x;
    logic signed [63:0] p_ref;

    always_comb begin
        din_x = 64'(signed'(din));
        p_ref = din_x * COEF_X;
        AST_WINDOW_EXACT: assert (res == RES_W'(p_ref >>> LSB_CUT)); // R1
        if (COEF_X == 0 || din == '0) begin
            AST_ZERO_RESULT: assert (res == '0); // R3
        end
        if (FULL && COEF_X == 1) begin
            AST_UNIT_PASS: assert (res == RES_W'(din_x)); // R2
        end
        if (FULL && COEF_X != 0 && din != '0) begin
            AST_SIGN_XOR: assert (res[RES_W-1] == (din[DIN_W-1] ^ COEF[K_W-1])); // R5
        end
    end

endmodule

bind ccg_gain ccg_gain_chk #(
    .DIN_W   (DIN_W),
    .K_W     (K_W),
    .COEF    (COEF),
    .DROP_MSB(DROP_MSB),
    .RES_W   (RES_W)
) u_chk (
    .din(din),
    .res(res)
);

// File: tb/sim_ccg_gain.sv
`timescale 1ns/1ps
module sim_ccg_gain;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    logic [5:0]  din = '0;
    logic signed [10:0] r0, r1, r2, r3, r4, r5;
    logic signed [5:0]  r6;
    logic        [4:0]  r7;
    logic signed [9:0]  r8;

    // K=11 full width
    ccg_gain #(.DIN_W(6), .K_W(5), .COEF(5'sd11), .DROP_MSB(0), .RES_W(11)) u0 (.din(din), .res(r0));
    // K=0
    ccg_gain #(.DIN_W(6), .K_W(5), .COEF(5'sd0), .DROP_MSB(0), .RES_W(11)) u1 (.din(din), .res(r1));
    // K=1
    ccg_gain #(.DIN_W(6), .K_W(5), .COEF(5'sd1), .DROP_MSB(0), .RES_W(11)) u2 (.din(din), .res(r2));
    // K=8, power of two
    ccg_gain #(.DIN_W(6), .K_W(5), .COEF(5'sd8), .DROP_MSB(0), .RES_W(11)) u3 (.din(din), .res(r3));
    // K=-16, most negative
    ccg_gain #(.DIN_W(6), .K_W(5), .COEF(5'sb10000), .DROP_MSB(0), .RES_W(11)) u4 (.din(din), .res(r4));
    // K=-7, mixed pattern 11001
    ccg_gain #(.DIN_W(6), .K_W(5), .COEF(5'sb11001), .DROP_MSB(0), .RES_W(11)) u5 (.din(din), .res(r5));
    // K=11, drop one MSB, keep 6, truncate 4
    ccg_gain #(.DIN_W(6), .K_W(5), .COEF(5'sd11), .DROP_MSB(1), .RES_W(6)) u6 (.din(din), .res(r6));
    // K=-16, keep top 5, truncate 6
    ccg_gain #(.DIN_W(6), .K_W(5), .COEF(5'sb10000), .DROP_MSB(0), .RES_W(5)) u7 (.din(din), .res(r7));
    // even coefficient width, K=-3 (1101)
    ccg_gain #(.DIN_W(6), .K_W(4), .COEF(4'sb1101), .DROP_MSB(0), .RES_W(10)) u8 (.din(din), .res(r8));

    task automatic chk(input string tag, input int act, input int exp, input int x);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s x=%0d actual=%0d expected=%0d", tag, x, act, exp);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // initial state with zero input: every instance reads zero (R3)
        chk("R3 zero-in u0", int'(r0), 0, 0);
        chk("R3 zero-in u4", int'(r4), 0, 0);
        chk("R3 zero-in u6", int'(r6), 0, 0);
        chk("R3 zero-in u7", int'(r7), 0, 0);
        chk("R3 zero-in u8", int'(r8), 0, 0);

        for (int x = -32; x < 32; x++) begin
            @(negedge clk);
            din = 6'(x);
            #1; // R9: sampled with no clock edge since the change
            chk("R2 K=11 full", int'(r0), x * 11, x);
            chk("R3 K=0", int'(r1), 0, x);
            chk("R2 K=1", int'(r2), x, x);
            chk("R2 K=8 pow2", int'(r3), x * 8, x);
            chk("R4 K=-16", int'(r4), x * -16, x);
            chk("R5 K=-7", int'(r5), x * -7, x);
            if (x != 0)
                chk("R5 sign xor", int'(r5[10]), (x < 0) ? 0 : 1, x);
            chk("R7 drop1 trunc4", int'(r6), (x * 11) >>> 4, x);
            chk("R1 window bits", int'(r6[5:0]), ((x * 11) >>> 4) & 63, x);
            chk("R6 trunc6 K=-16", int'(r7), ((x * -16) >>> 6) & 31, x);
            chk("R8 even K_W K=-3", int'(r8), x * -3, x);
        end
        // corner: most negative times most negative
        @(negedge clk);
        din = 6'b100000;
        #1;
        chk("R4 minxmin", int'(r4), 512, -32);
        chk("R6 minxmin window", int'(r7), 8, -32);
        chk("R9 settle", int'(r3), -256, -32);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=done");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule